// File: doc/BRIEF.md
# Sorted Directory Insertion Unit

This block maintains a small directory of named items that always stays sorted. Items arrive one at a time as add requests. Each request carries a fixed-width packed name, a 32-bit length, an order rank, an override rank and a mode flag. The unit first rejects the request if the directory is already full. It then rejects it if the name is already present. Otherwise it searches for the insertion point and moves every later entry up by one slot. It writes the new entry and gives every entry it touched a new selector number equal to a base value plus its slot index.

In normal mode the order is a byte-wise comparison of names, with the first character in the most significant byte. In legacy mode the order is a numeric rank. That rank is the override rank when the override is nonzero. Otherwise it is the supplied rank, and an unknown rank (zero) becomes the last rank, 200. Equal keys keep their arrival order. The search and the shift share one pass that moves one slot per clock. While that pass runs, a busy flag is high and further requests are ignored. The pass ends with a one-cycle done pulse that carries the assigned slot and the error flags.

A combinational read port shows the name, length, selector and rank held in any slot. The entry count and the stored lengths are given in big-endian byte order.

Top module: `sorted_dir_insert`

## Requirements
- R1: After reset the count is zero, busy and done are low, and no slot reads as valid.
- R2: In normal mode, entries read back in ascending unsigned order of their names. Name byte NAME_BYTES-1 (bits [NAME_W-1:NAME_W-8]) is the first character. A shorter name padded with zero bytes sorts before any longer name that starts with it.
- R3: An entry whose key equals the keys of existing entries is placed after all of them.
- R4: In legacy mode the key is the effective rank. It equals add_ovr_rank_i when that is nonzero, else add_rank_i when that is nonzero, else 200. The read port shows the effective rank; in normal mode it shows 0.
- R5: Every valid slot i reads back the selector SEL_BASE + i, and a moved entry keeps its name, length and rank.
- R6: An add whose name equals the name of a valid entry ends with dup_o = 1 and leaves the directory and the count unchanged.
- R7: An add while the count equals SLOTS ends with full_o = 1 and dup_o = 0, even if the name is a duplicate. The directory is left unchanged.
- R8: count_be_o is the 32-bit count with its bytes reversed. Bits [7:0] hold the most significant byte. rd_size_be_o holds the stored length reversed in the same way. A successful add raises the count by exactly one.
- R9: Let the accepting clock edge be edge 1. done_o is high for one cycle after edge 1 for a full reject, after edge 2 for a duplicate, and after edge 3+S for an insertion that moves S entries. busy_o is high from acceptance through the done cycle, and add_i is ignored while busy_o is high.
- R10: On a successful add, slot_o gives the index at which the new entry was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| add_i | input | 1 | Add request, sampled while idle |
| add_name_i | input | NAME_BYTES*8 | Packed name, first character in the top byte |
| add_size_i | input | 32 | Item length |
| add_rank_i | input | RANK_W | Looked-up rank, 0 means unknown |
| add_ovr_rank_i | input | RANK_W | Override rank, used when nonzero |
| add_legacy_i | input | 1 | 1 = sort by rank, 0 = sort by name |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| slot_o | output | $clog2(SLOTS) | Slot given to the new entry |
| dup_o | output | 1 | Request rejected, name already present |
| full_o | output | 1 | Request rejected, directory full |
| count_be_o | output | 32 | Entry count, bytes reversed |
| rd_idx_i | input | $clog2(SLOTS) | Read port slot index |
| rd_valid_o | output | 1 | Read slot holds an entry |
| rd_name_o | output | NAME_BYTES*8 | Name in the read slot |
| rd_size_be_o | output | 32 | Length in the read slot, bytes reversed |
| rd_sel_o | output | SEL_W | Selector of the read slot |
| rd_rank_o | output | RANK_W | Rank of the read slot |

## Verification
Random short names over a four-letter alphabet produce both shared prefixes and frequent duplicates. The shared prefixes separate a correct first-difference byte compare from a compare that ignores padding. The duplicates exercise the reject path at many fill levels. Legacy runs use repeated ranks, unknown ranks and overrides, which show whether equal keys keep their arrival order and whether the rank is chosen correctly. A run of names in strictly falling order forces the longest shift on every add and fills the directory. A full-time add with a duplicate name then shows that the full check comes before the duplicate check. Extra requests made while the unit is busy show whether the block is properly blocked during a pass.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_SCAN, ST_DONE} dir_state_e;

  function automatic logic [31:0] bswap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
endpackage

// File: rtl/dir_key_cmp.sv
module dir_key_cmp #(
  parameter int NAME_BYTES = 56,
  parameter int RANK_W     = 8,
  localparam int NAME_W    = NAME_BYTES * 8
) (
  input  logic              legacy_i,
  input  logic [NAME_W-1:0] a_name_i,
  input  logic [NAME_W-1:0] b_name_i,
  input  logic [RANK_W-1:0] a_rank_i,
  input  logic [RANK_W-1:0] b_rank_i,
  output logic              lt_o
);
  logic name_lt;

  // first differing byte decides, top byte first
  always_comb begin
    logic found;
    found   = 1'b0;
    name_lt = 1'b0;
    for (int b = NAME_BYTES - 1; b >= 0; b--) begin
      if (!found && (a_name_i[b*8 +: 8] != b_name_i[b*8 +: 8])) begin
        found   = 1'b1;
        name_lt = a_name_i[b*8 +: 8] < b_name_i[b*8 +: 8];
      end
    end
  end

  assign lt_o = legacy_i ? (a_rank_i < b_rank_i) : name_lt;
endmodule

// File: rtl/dir_slot_store.sv
module dir_slot_store #(
  parameter int SLOTS  = 32,
  parameter int EW     = 512,
  parameter int NAME_W = 448,
  parameter int IDX_W  = 5,
  parameter int CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [EW-1:0]     wr_data_i,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  output logic [EW-1:0]     rd_a_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [EW-1:0]     rd_b_o,
  input  logic [NAME_W-1:0] key_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [SLOTS-1:0]  match_o
);
  localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(SLOTS);

  logic [EW-1:0] ent_q [SLOTS];

  for (genvar j = 0; j < SLOTS; j++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    ent_q[j] <= '0;
      else if (wr_en_i && (wr_idx_i == IDX_W'(j)))    ent_q[j] <= wr_data_i;
    end
    assign match_o[j] = (CNT_W'(j) < count_i) && (ent_q[j][EW-1 -: NAME_W] == key_i);
  end

  assign rd_a_o = (CNT_W'(rd_a_idx_i) < SLOTS_C) ? ent_q[rd_a_idx_i] : '0;
  assign rd_b_o = (CNT_W'(rd_b_idx_i) < SLOTS_C) ? ent_q[rd_b_idx_i] : '0;
endmodule

// File: rtl/dir_insert_ctrl.sv
module dir_insert_ctrl
  import dir_pkg::*;
#(
  parameter int SLOTS     = 32,
  parameter int NAME_W    = 448,
  parameter int RANK_W    = 8,
  parameter int SEL_W     = 16,
  parameter int SEL_BASE  = 32,
  parameter int LAST_RANK = 200,
  parameter int IDX_W     = 5,
  parameter int CNT_W     = 6,
  parameter int EW        = 504
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              add_i,
  input  logic [NAME_W-1:0] add_name_i,
  input  logic [31:0]       add_size_i,
  input  logic [RANK_W-1:0] add_rank_i,
  input  logic [RANK_W-1:0] add_ovr_rank_i,
  input  logic              add_legacy_i,
  input  logic [EW-1:0]     prev_ent_i,
  input  logic              lt_i,
  input  logic              dup_any_i,
  output logic [IDX_W-1:0]  prev_idx_o,
  output logic [NAME_W-1:0] req_name_o,
  output logic [RANK_W-1:0] req_rank_o,
  output logic              req_legacy_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [EW-1:0]     wr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [IDX_W-1:0]  slot_o,
  output logic              dup_o,
  output logic              full_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(SLOTS);

  dir_state_e        state_q;
  logic [IDX_W-1:0]  pos_q, slot_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [NAME_W-1:0] req_name_q;
  logic [31:0]       req_size_q;
  logic [RANK_W-1:0] req_rank_q, eff_rank;
  logic              req_leg_q, dup_q, full_q, shift_w;
  logic [SEL_W-1:0]  new_sel;

  always_comb begin
    if (add_ovr_rank_i != '0)  eff_rank = add_ovr_rank_i;
    else if (add_rank_i != '0) eff_rank = add_rank_i;
    else                       eff_rank = RANK_W'(LAST_RANK);
  end

  assign shift_w    = (state_q == ST_SCAN) && (pos_q != '0) && lt_i;
  assign prev_idx_o = pos_q - IDX_W'(1);
  assign new_sel    = SEL_W'(SEL_BASE) + SEL_W'(pos_q);

  always_comb begin
    wr_en_o  = (state_q == ST_SCAN);
    wr_idx_o = pos_q;
    if (shift_w) wr_data_o = {prev_ent_i[EW-1 -: NAME_W+32], new_sel, prev_ent_i[RANK_W-1:0]};
    else         wr_data_o = {req_name_q, bswap32(req_size_q), new_sel, req_rank_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      pos_q      <= '0;
      slot_q     <= '0;
      cnt_q      <= '0;
      req_name_q <= '0;
      req_size_q <= '0;
      req_rank_q <= '0;
      req_leg_q  <= 1'b0;
      dup_q      <= 1'b0;
      full_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (add_i) begin
          req_name_q <= add_name_i;
          req_size_q <= add_size_i;
          req_rank_q <= add_legacy_i ? eff_rank : '0;
          req_leg_q  <= add_legacy_i;
          dup_q      <= 1'b0;
          slot_q     <= '0;
          full_q     <= (cnt_q == FULL_CNT);
          state_q    <= (cnt_q == FULL_CNT) ? ST_DONE : ST_CHECK;
        end
        ST_CHECK: begin
          dup_q   <= dup_any_i;
          pos_q   <= IDX_W'(cnt_q);
          state_q <= dup_any_i ? ST_DONE : ST_SCAN;
        end
        ST_SCAN: begin
          if (shift_w) begin
            pos_q <= pos_q - IDX_W'(1);
          end else begin
            slot_q  <= pos_q;
            cnt_q   <= cnt_q + CNT_W'(1);
            state_q <= ST_DONE;
          end
        end
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_DONE);
  assign slot_o       = slot_q;
  assign dup_o        = dup_q;
  assign full_o       = full_q;
  assign count_o      = cnt_q;
  assign req_name_o   = req_name_q;
  assign req_rank_o   = req_rank_q;
  assign req_legacy_o = req_leg_q;
endmodule

// File: rtl/sorted_dir_insert.sv
module sorted_dir_insert
  import dir_pkg::*;
#(
  parameter int SLOTS      = 32,
  parameter int NAME_BYTES = 56,
  parameter int RANK_W     = 8,
  parameter int SEL_W      = 16,
  parameter int SEL_BASE   = 32,
  parameter int LAST_RANK  = 200,
  localparam int NAME_W    = NAME_BYTES * 8,
  localparam int IDX_W     = $clog2(SLOTS),
  localparam int CNT_W     = $clog2(SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              add_i,
  input  logic [NAME_W-1:0] add_name_i,
  input  logic [31:0]       add_size_i,
  input  logic [RANK_W-1:0] add_rank_i,
  input  logic [RANK_W-1:0] add_ovr_rank_i,
  input  logic              add_legacy_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [IDX_W-1:0]  slot_o,
  output logic              dup_o,
  output logic              full_o,
  output logic [31:0]       count_be_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [NAME_W-1:0] rd_name_o,
  output logic [31:0]       rd_size_be_o,
  output logic [SEL_W-1:0]  rd_sel_o,
  output logic [RANK_W-1:0] rd_rank_o
);
  localparam int EW = NAME_W + 32 + SEL_W + RANK_W;

  logic [EW-1:0]     prev_ent, rd_ent, wr_data;
  logic [IDX_W-1:0]  prev_idx, wr_idx;
  logic [NAME_W-1:0] req_name;
  logic [RANK_W-1:0] req_rank;
  logic [SLOTS-1:0]  match;
  logic [CNT_W-1:0]  cnt;
  logic              req_legacy, lt, wr_en;

  dir_key_cmp #(.NAME_BYTES(NAME_BYTES), .RANK_W(RANK_W)) u_cmp (
    .legacy_i (req_legacy),
    .a_name_i (req_name),
    .b_name_i (prev_ent[EW-1 -: NAME_W]),
    .a_rank_i (req_rank),
    .b_rank_i (prev_ent[RANK_W-1:0]),
    .lt_o     (lt)
  );

  dir_slot_store #(
    .SLOTS(SLOTS), .EW(EW), .NAME_W(NAME_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_data_i  (wr_data),
    .rd_a_idx_i (rd_idx_i),
    .rd_a_o     (rd_ent),
    .rd_b_idx_i (prev_idx),
    .rd_b_o     (prev_ent),
    .key_i      (req_name),
    .count_i    (cnt),
    .match_o    (match)
  );

  dir_insert_ctrl #(
    .SLOTS(SLOTS), .NAME_W(NAME_W), .RANK_W(RANK_W), .SEL_W(SEL_W),
    .SEL_BASE(SEL_BASE), .LAST_RANK(LAST_RANK), .IDX_W(IDX_W),
    .CNT_W(CNT_W), .EW(EW)
  ) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .add_i          (add_i),
    .add_name_i     (add_name_i),
    .add_size_i     (add_size_i),
    .add_rank_i     (add_rank_i),
    .add_ovr_rank_i (add_ovr_rank_i),
    .add_legacy_i   (add_legacy_i),
    .prev_ent_i     (prev_ent),
    .lt_i           (lt),
    .dup_any_i      (|match),
    .prev_idx_o     (prev_idx),
    .req_name_o     (req_name),
    .req_rank_o     (req_rank),
    .req_legacy_o   (req_legacy),
    .wr_en_o        (wr_en),
    .wr_idx_o       (wr_idx),
    .wr_data_o      (wr_data),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .slot_o         (slot_o),
    .dup_o          (dup_o),
    .full_o         (full_o),
    .count_o        (cnt)
  );

  assign count_be_o   = bswap32(32'(cnt));
  assign rd_valid_o   = CNT_W'(rd_idx_i) < cnt;
  assign rd_name_o    = rd_ent[EW-1 -: NAME_W];
  assign rd_size_be_o = rd_ent[SEL_W+RANK_W +: 32];
  assign rd_sel_o     = rd_ent[RANK_W +: SEL_W];
  assign rd_rank_o    = rd_ent[RANK_W-1:0];
endmodule

// File: rtl/dir_insert_chk.sv
module dir_insert_chk #(
  parameter int SLOTS = 32,
  parameter int IDX_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             add_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             dup_o,
  input logic             full_o,
  input logic [IDX_W-1:0] slot_o,
  input logic [31:0]      count_be_o
);
  logic [31:0] cnt_w;
  assign cnt_w = dir_pkg::bswap32(count_be_o);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);                                                   // R9
  AST_DONE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);                                                    // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_i && !busy_o) |=> busy_o);                                        // R9
  AST_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(dup_o && full_o));                                        // R6
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_w != $past(cnt_w)) |-> (done_o && !dup_o && !full_o && cnt_w == $past(cnt_w) + 32'd1)); // R8
  AST_FULL_AT_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && full_o) |-> (cnt_w == 32'(SLOTS)));                        // R7
  AST_COUNT_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_w <= 32'(SLOTS));                                                  // R7
  AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !dup_o && !full_o) |-> (32'(slot_o) < cnt_w));             // R10
endmodule

bind sorted_dir_insert dir_insert_chk #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .add_i      (add_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .dup_o      (dup_o),
  .full_o     (full_o),
  .slot_o     (slot_o),
  .count_be_o (count_be_o)
);

// File: tb/sorted_dir_insert_test.sv
`timescale 1ns/1ps
module sorted_dir_insert_test;
  localparam int SLOTS = 32, NAME_BYTES = 56, NAME_W = NAME_BYTES * 8;
  localparam int IDX_W = 5, RANK_W = 8, SEL_W = 16, SEL_BASE = 32;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic add_i = 1'b0, add_legacy_i = 1'b0;
  logic [NAME_W-1:0] add_name_i = '0;
  logic [31:0] add_size_i = '0;
  logic [RANK_W-1:0] add_rank_i = '0, add_ovr_rank_i = '0;
  logic busy_o, done_o, dup_o, full_o, rd_valid_o;
  logic [IDX_W-1:0] slot_o, rd_idx_i = '0;
  logic [31:0] count_be_o, rd_size_be_o;
  logic [NAME_W-1:0] rd_name_o;
  logic [SEL_W-1:0] rd_sel_o;
  logic [RANK_W-1:0] rd_rank_o;

  sorted_dir_insert #(.SLOTS(SLOTS), .NAME_BYTES(NAME_BYTES), .RANK_W(RANK_W),
    .SEL_W(SEL_W), .SEL_BASE(SEL_BASE), .LAST_RANK(200)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .add_i(add_i), .add_name_i(add_name_i),
    .add_size_i(add_size_i), .add_rank_i(add_rank_i), .add_ovr_rank_i(add_ovr_rank_i),
    .add_legacy_i(add_legacy_i), .busy_o(busy_o), .done_o(done_o), .slot_o(slot_o),
    .dup_o(dup_o), .full_o(full_o), .count_be_o(count_be_o), .rd_idx_i(rd_idx_i),
    .rd_valid_o(rd_valid_o), .rd_name_o(rd_name_o), .rd_size_be_o(rd_size_be_o),
    .rd_sel_o(rd_sel_o), .rd_rank_o(rd_rank_o));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0, m_cnt = 0;
  logic [NAME_W-1:0] m_name [SLOTS];
  logic [31:0]       m_size [SLOTS];
  logic [RANK_W-1:0] m_rank [SLOTS];

  function automatic logic [31:0] rev32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [NAME_W-1:0] mk_name(input logic [7:0] c0, c1, c2);
    logic [NAME_W-1:0] n = '0;
    n[NAME_W-1 -: 8]  = c0;
    n[NAME_W-9 -: 8]  = c1;
    n[NAME_W-17 -: 8] = c2;
    return n;
  endfunction

  function automatic logic [NAME_W-1:0] rnd_name();
    int len = 1 + int'($urandom % 3);
    logic [7:0] c0 = 8'h61 + 8'($urandom % 4);
    logic [7:0] c1 = (len > 1) ? 8'h61 + 8'($urandom % 4) : 8'h00;
    logic [7:0] c2 = (len > 2) ? 8'h61 + 8'($urandom % 4) : 8'h00;
    return mk_name(c0, c1, c2);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    add_i  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    m_cnt  = 0;
  endtask

  task automatic sweep(input string tag);
    bit ok;
    for (int i = 0; i < SLOTS; i++) begin
      rd_idx_i = IDX_W'(i);
      #1;
      ok = (rd_valid_o == (i < m_cnt));
      if (i < m_cnt)
        ok = ok && rd_name_o == m_name[i] && rd_size_be_o == rev32(m_size[i]) &&
             rd_sel_o == SEL_W'(SEL_BASE + i) && rd_rank_o == m_rank[i];
      chk(ok, tag, $sformatf("slot %0d valid=%0b name=%h size=%h sel=%0d rank=%0d exp valid=%0b name=%h size=%h sel=%0d rank=%0d",
          i, rd_valid_o, rd_name_o[NAME_W-1 -: 24], rd_size_be_o, rd_sel_o, rd_rank_o,
          (i < m_cnt), m_name[i][NAME_W-1 -: 24], rev32(m_size[i]), SEL_BASE + i, m_rank[i]));
    end
  endtask

  task automatic do_add(input logic [NAME_W-1:0] nm, input logic [31:0] sz,
                        input logic [RANK_W-1:0] rk, input logic [RANK_W-1:0] ov,
                        input bit leg, input bit poke);
    logic [RANK_W-1:0] er;
    bit e_full, e_dup, seen;
    int pos, e_lat, lat;
    er = (ov != 0) ? ov : ((rk != 0) ? rk : RANK_W'(200));
    if (!leg) er = '0;
    e_full = (m_cnt == SLOTS);
    e_dup  = 1'b0;
    for (int i = 0; i < m_cnt; i++) if (m_name[i] == nm) e_dup = 1'b1;
    e_dup = e_dup && !e_full;
    pos = m_cnt;
    while (pos > 0 && (leg ? (er < m_rank[pos-1]) : (nm < m_name[pos-1]))) pos--;
    e_lat = e_full ? 1 : (e_dup ? 2 : 3 + m_cnt - pos);

    @(negedge clk);
    add_name_i = nm; add_size_i = sz; add_rank_i = rk;
    add_ovr_rank_i = ov; add_legacy_i = leg; add_i = 1'b1;
    @(posedge clk);
    #1;
    add_i = poke;
    if (poke) add_name_i = mk_name(8'h51, 8'h51, 8'h51);
    lat = 1; seen = 1'b0;
    while (lat < 80) begin
      @(negedge clk);
      if (done_o) begin seen = 1'b1; break; end
      @(posedge clk);
      #1;
      add_i = 1'b0;
      lat++;
    end
    add_i = 1'b0;
    chk(seen && lat == e_lat && busy_o, "R9", $sformatf("latency %0d busy %0b exp %0d busy 1", lat, busy_o, e_lat));
    chk(full_o == e_full, "R7", $sformatf("full %0b exp %0b", full_o, e_full));
    chk(dup_o == e_dup, "R6", $sformatf("dup %0b exp %0b", dup_o, e_dup));
    if (!e_full && !e_dup) begin
      chk(int'(slot_o) == pos, "R10", $sformatf("slot %0d exp %0d", slot_o, pos));
      for (int i = m_cnt; i > pos; i--) begin
        m_name[i] = m_name[i-1]; m_size[i] = m_size[i-1]; m_rank[i] = m_rank[i-1];
      end
      m_name[pos] = nm; m_size[pos] = sz; m_rank[pos] = er;
      m_cnt++;
    end
    @(posedge clk);
    #1;
    chk(!done_o && !busy_o, "R9", $sformatf("after pulse done %0b busy %0b exp 0 0", done_o, busy_o));
    chk(count_be_o == rev32(32'(m_cnt)), "R8", $sformatf("count_be %h exp %h", count_be_o, rev32(32'(m_cnt))));
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL R9: watchdog expired, actual hung, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < SLOTS; i++) begin m_name[i] = '0; m_size[i] = '0; m_rank[i] = '0; end
    do_reset();
    chk(count_be_o == 0 && !done_o && !busy_o, "R1",
        $sformatf("count %h done %0b busy %0b exp 0 0 0", count_be_o, done_o, busy_o));
    sweep("R1");

    // normal mode, directed prefixes and duplicates
    do_add(mk_name("b", 0, 0), 32'h11223344, 0, 0, 0, 0);
    do_add(mk_name("a", 0, 0), 32'h00000010, 0, 0, 0, 0);
    do_add(mk_name("a", "b", 0), 32'h00000020, 0, 0, 0, 1);
    do_add(mk_name("a", 0, 0), 32'h00000030, 0, 0, 0, 0);
    do_add(mk_name("b", "a", 0), 32'hA0B0C0D0, 0, 0, 0, 0);
    sweep("R2");
    sweep("R8");
    for (int k = 0; k < 40; k++) begin
      do_add(rnd_name(), $urandom, 0, 0, 0, (k % 3) == 0);
      sweep("R5");
    end

    // legacy mode
    do_reset();
    chk(count_be_o == 0 && !busy_o, "R1", $sformatf("count %h busy %0b exp 0 0", count_be_o, busy_o));
    do_add(mk_name("L", 1, 0), 32'd1, 50, 0, 1, 0);
    do_add(mk_name("L", 2, 0), 32'd2, 10, 0, 1, 0);
    do_add(mk_name("L", 3, 0), 32'd3, 50, 0, 1, 0);
    sweep("R3");
    do_add(mk_name("L", 4, 0), 32'd4, 0, 0, 1, 0);
    do_add(mk_name("L", 5, 0), 32'd5, 150, 5, 1, 0);
    do_add(mk_name("L", 6, 0), 32'd6, 200, 0, 1, 1);
    sweep("R4");
    do_add(mk_name("L", 3, 0), 32'd7, 1, 0, 1, 0);
    for (int k = 0; k < 20; k++) begin
      logic [RANK_W-1:0] rr, oo;
      rr = RANK_W'(($urandom % 4) * 10);
      oo = (($urandom % 5) == 0) ? RANK_W'(1 + $urandom % 40) : '0;
      do_add(mk_name("L", 8'(10 + k), 0), $urandom, rr, oo, 1, 0);
      sweep("R4");
    end

    // fill with falling names, then full rejects
    do_reset();
    for (int k = 0; k < SLOTS; k++) do_add(mk_name("F", 8'(100 - k), 0), 32'(k), 0, 0, 0, 0);
    sweep("R5");
    do_add(mk_name("F", 1, 0), 32'd99, 0, 0, 0, 0);
    do_add(mk_name("F", 100, 0), 32'd98, 0, 0, 0, 0);
    sweep("R7");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule